// File: doc/BRIEF.md
# Character and Line Raster Timing Generator

This block frames one page of a text raster. A character counter steps once per character time and names the column being scanned. A line counter steps on each end-of-line pulse. From the two counts the block decodes the timing marks that the rest of the display path needs: line start, line end, page start, the mid-page and end-of-page mark, page end, and horizontal and vertical sync.

A line spans 64 character times: 54 displayed columns followed by a 10-character retrace. End-of-line is not taken from the counter wrap. It is taken at column 55, qualified by the strobe of the character's last bit. The line counter therefore steps while the line still has eight character times left. After the twentieth line's end-of-line, the line count reads 20. That value marks the retrace tail of the page. At the final character time of that tail, end-of-page is raised and both counters fall back to zero on the next character tick. A page is therefore exactly 1280 character times (1080 displayed, 200 retrace), which keeps it in step with a recirculating page store.

All decodes other than end-of-line are taken from the registered counts. Each one holds for the whole character time it marks. End-of-line lasts one clock, in the cycle where the last-bit strobe arrives.

Top module: `raster_timer`

## Requirements
- R1: While `rst` is high, and on the first sample after it falls, `char_cnt` and `line_cnt` are 0, so `bol` and `bop` are 1 and `eop`, `coeop`, `hsync`, `vsync` are 0.
- R2: `char_cnt` rises by one at each clock edge where `char_tick` is high, wrapping from 63 to 0, and holds at every other edge.
- R3: `eol` is high exactly in the clock cycles where `last_bit` is high while `char_cnt` is 55. A `last_bit` pulse at any other column leaves `line_cnt` unchanged.
- R4: Each `eol` cycle adds one to `line_cnt` at the next edge, including when `char_tick` is high in the same cycle.
- R5: `bol` is high while `char_cnt` is 0. `bop` is high while both counts are 0.
- R6: `eop` is high while `char_cnt` is 63 and `line_cnt` is 20. A `char_tick` in that state returns both counters to 0, so successive end-of-page ticks are exactly 1280 character ticks apart.
- R7: `coeop` is high while `char_cnt` is 63 and `line_cnt` is 10 (centre of page) or 20 (end of page).
- R8: `hsync` is high while `char_cnt` is between 57 and 60 inclusive.
- R9: `vsync` is high while `line_cnt` is 20, that is, from the twentieth end-of-line until the page wraps. `line_cnt` never exceeds 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| char_tick | input | 1 | One-clock character-count trigger, once per character time |
| last_bit | input | 1 | One-clock strobe of the character's last bit time |
| char_cnt | output | 6 | Current column, 0 to 63 |
| line_cnt | output | 5 | Lines ended in this page, 0 to 20 |
| bol | output | 1 | Beginning of line |
| eol | output | 1 | End of line, one clock |
| bop | output | 1 | Beginning of page |
| coeop | output | 1 | Centre-or-end-of-page mark |
| eop | output | 1 | End of page |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The last-bit strobe of column 55 and the character tick that leaves column 55 can land in the same clock. In that case the column must still advance to 56 and the line count must still rise by one. The bench randomises where the strobe falls inside the column-55 character time, and it runs one whole page with the strobe forced onto the tick cycle. A reference model steps both counts independently and is compared against every decode after each clock. A 1280-tick spacing between end-of-page ticks then shows that no line step was lost or doubled.

// File: rtl/raster_timer.sv
module raster_timer #(
  parameter int CHAR_W   = 6,
  parameter int LINE_W   = 5,
  parameter int LINES    = 20,
  parameter int EOL_CHAR = 55,
  parameter int HS_START = 57,
  parameter int HS_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_tick,
  input  logic              last_bit,
  output logic [CHAR_W-1:0] char_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              bol,
  output logic              eol,
  output logic              bop,
  output logic              coeop,
  output logic              eop,
  output logic              hsync,
  output logic              vsync
);
  localparam logic [CHAR_W-1:0] LAST_C = '1;
  localparam logic [CHAR_W-1:0] EOL_C  = CHAR_W'(EOL_CHAR);
  localparam logic [CHAR_W-1:0] HS_A   = CHAR_W'(HS_START);
  localparam logic [CHAR_W-1:0] HS_B   = CHAR_W'(HS_START + HS_LEN);
  localparam logic [LINE_W-1:0] END_L  = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] MID_L  = LINE_W'(LINES / 2);

  logic at_last;

  assign at_last = (char_cnt == LAST_C);
  assign bol     = (char_cnt == '0);
  assign bop     = bol && (line_cnt == '0);
  assign eol     = last_bit && (char_cnt == EOL_C);
  assign eop     = at_last && (line_cnt == END_L);
  assign coeop   = at_last && ((line_cnt == MID_L) || (line_cnt == END_L));
  assign hsync   = (char_cnt >= HS_A) && (char_cnt < HS_B);
  assign vsync   = (line_cnt == END_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      char_cnt <= '0;
      line_cnt <= '0;
    end else begin
      if (char_tick) char_cnt <= char_cnt + 1'b1;
      if (char_tick && eop) line_cnt <= '0;
      else if (eol)         line_cnt <= line_cnt + 1'b1;
    end
  end

  // R2
  char_step_chk: assert property (@(posedge clk) disable iff (rst)
    char_tick |=> char_cnt == CHAR_W'($past(char_cnt) + 1'b1));

  // R2
  char_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !char_tick |=> $stable(char_cnt));

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    eol |=> line_cnt == LINE_W'($past(line_cnt) + 1'b1));

  // R6
  page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (eop && char_tick) |=> (char_cnt == '0 && line_cnt == '0));

  // R9
  line_bound_chk: assert property (@(posedge clk) disable iff (rst)
    line_cnt <= END_L);

  // R5
  bop_eop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bop, eop}));
endmodule

// File: tb/raster_timer_test.sv
module raster_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_tick = 1'b0;
  logic       last_bit = 1'b0;
  logic [5:0] char_cnt;
  logic [4:0] line_cnt;
  logic       bol, eol, bop, coeop, eop, hsync, vsync;

  int checks = 0;
  int fails = 0;
  int mc = 0;
  int ml = 0;
  int ticks_since = 0;
  int pages = 0;
  bit done = 0;

  always #4 clk = ~clk;

  raster_timer uut (
    .clk(clk), .rst(rst), .char_tick(char_tick), .last_bit(last_bit),
    .char_cnt(char_cnt), .line_cnt(line_cnt), .bol(bol), .eol(eol),
    .bop(bop), .coeop(coeop), .eop(eop), .hsync(hsync), .vsync(vsync)
  );

  function automatic int exp_eop(int c, int l);
    return int'(c == 63 && l == 20);
  endfunction
  function automatic int exp_coeop(int c, int l);
    return int'(c == 63 && (l == 10 || l == 20));
  endfunction
  function automatic int exp_hsync(int c);
    return int'(c >= 57 && c <= 60);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (col %0d line %0d)", req, act, exp, mc, ml);
    end
  endtask

  task automatic check_state();
    chk("R2 char_cnt", int'(char_cnt), mc);
    chk("R4 line_cnt", int'(line_cnt), ml);
    chk("R5 bol", int'(bol), int'(mc == 0));
    chk("R5 bop", int'(bop), int'(mc == 0 && ml == 0));
    chk("R6 eop", int'(eop), exp_eop(mc, ml));
    chk("R7 coeop", int'(coeop), exp_coeop(mc, ml));
    chk("R8 hsync", int'(hsync), exp_hsync(mc));
    chk("R9 vsync", int'(vsync), int'(ml == 20));
  endtask

  task automatic step(input logic t, input logic lb);
    int pe;
    @(negedge clk);
    char_tick = t;
    last_bit = lb;
    #1;
    check_state();
    chk("R3 eol", int'(eol), int'(lb && mc == 55));
    pe = exp_eop(mc, ml);
    if (t) begin
      ticks_since++;
      if (pe == 1) begin
        chk("R6 page period", ticks_since, 1280);
        ticks_since = 0;
        pages++;
      end
    end
    if (t && pe == 1) ml = 0;
    else if (lb && mc == 55) ml = ml + 1;
    if (t) mc = (mc + 1) % 64;
  endtask

  task automatic char_time(input bit force_co);
    int gap, pos;
    bit at55;
    gap = int'($urandom_range(0, 2));
    pos = force_co ? gap : int'($urandom_range(0, gap));
    at55 = (mc == 55);
    for (int i = 0; i <= gap; i++) begin
      logic lb;
      if (at55) lb = (i == pos);
      else lb = ($urandom_range(0, 7) == 0);
      step(i == gap, lb);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    char_tick = 1'b0;
    last_bit = 1'b0;
    repeat (2) @(negedge clk);
    mc = 0;
    ml = 0;
    ticks_since = 0;
    #1;
    chk("R1 char_cnt in reset", int'(char_cnt), 0);
    chk("R1 line_cnt in reset", int'(line_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R1 bol after reset", int'(bol), 1);
    chk("R1 bop after reset", int'(bop), 1);
    chk("R1 eop after reset", int'(eop | coeop | hsync | vsync), 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    for (int n = 0; n < 2 * 1280; n++) char_time(1'b0);
    chk("R6 pages seen", pages, 2);
    for (int n = 0; n < 1280; n++) char_time(1'b1);
    chk("R4 coincident page", pages, 3);
    for (int n = 0; n < 700; n++) char_time(1'b0);
    do_reset();
    for (int n = 0; n < 1300; n++) char_time(1'b0);
    chk("R6 page after reset", pages, 4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule